// File: doc/BRIEF.md
# Floating-point mode register access arbiter

This block decides what happens when software tries to read or write the floating-point mode control register. Each clock it samples the current privilege level (0 to 3) and the control state that governs the access. That state covers whether levels 2 and 3 are present and active, the host-mode and trap-general routing bits, and four mode-register enable bits: level 1, level 2 in host mode, the level 2 extension control and level 3. It also covers the FP access fields at levels 1 and 2, the FP trap bits at levels 2 and 3, an early-undefined option and an undefined-on-trap option. The block walks a fixed priority chain for the sampled level. It registers exactly one verdict: access granted, undefined instruction, or trap. A trap carries a target level and a 6-bit exception class.

The verdict sits in a small state register with three named states. `VD_UNDEF` is the reset state and means undefined instruction. `VD_GRANT` means the access is granted. `VD_TRAP` means the access traps, with the target level and class held beside it. On every rising clock edge out of reset, the register moves from whatever state it holds to the state chosen by the inputs sampled at that edge. Any state can move to any other. An asynchronous active-low reset forces `VD_UNDEF`. Register storage and exception entry belong to neighbouring blocks. Reads and writes follow the same rules.

Top module: `fpmc_access_arbiter`

## Requirements
- R1: With `feat_present` low, the verdict is undefined at every level, whatever the other inputs are.
- R2: Exactly one of `grant`, `undef`, `trap` is high in every cycle. `tgt_lvl` and `exc_class` are 0 unless `trap` is high.
- R3: At levels 0 to 2, the verdict is undefined ahead of every other check when `l3_present` and `early_undef` are high and either `mode_en_l3` is low or `fp_trap_l3` is high.
- R4: A cleared mode-register enable traps with class 0x18. The targets are: at level 0, `mode_en_l1` low goes to level 1, or to level 2 when `l2_active` and `trap_general` are both high; `mode_en_l2h` low with `host_l0` high goes to level 2; at levels 0 and 1 without host mode, when `l2_active` is high and either `ext2_on` or `mode_en_ext2` is low, the trap goes to level 2; `mode_en_l3` low with level 3 present goes to level 3.
- R5: At level 0 without host mode, an `fp_acc_l1` value other than 2'b11 traps to level 1 with class 0x07. It goes to level 2 with class 0x00 when `l2_active` and `trap_general` are both high.
- R6: At levels 1 and 2, an FP access field with bit 0 clear disables access and traps with class 0x07. The field is `fp_acc_l1` at level 1, and `fp_acc_l2` when `host_l2` is high. A value of 2'b01 grants at level 1, although it traps at level 0.
- R7: Mode-enable causes rank above FP access causes. FP trap-bit causes come last, level 2 before level 3.
- R8: At levels 0 to 2, a trap that would target level 3 becomes undefined when `undef_on_trap` is high.
- R9: At level 3, only `fp_trap_l3` matters. When it is high, the access traps to level 3 with class 0x07, and `undef_on_trap` does not convert it. When it is low, the access is granted.
- R10: `acc_write` has no effect: a read and a write with the same other inputs get the same verdict.
- R11: The verdict appears on the outputs in the cycle after the rising edge that sampled the inputs. During reset the outputs show undefined, with target and class 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feat_present | input | 1 | Mode register implemented |
| cur_lvl | input | 2 | Privilege level of the access |
| l3_present | input | 1 | Level 3 exists |
| l2_active | input | 1 | Level 2 enabled for this access |
| host_l0 | input | 1 | Level 0 runs under a level-2 host |
| host_l2 | input | 1 | Level 2 runs in host mode |
| trap_general | input | 1 | Routes level-0 exceptions to level 2 |
| ext2_on | input | 1 | Level 2 extension control is in effect |
| mode_en_l1 | input | 1 | Level 1 mode-register enable |
| mode_en_l2h | input | 1 | Level 2 (host) mode-register enable |
| mode_en_ext2 | input | 1 | Level 2 extension mode-register enable |
| mode_en_l3 | input | 1 | Level 3 mode-register enable |
| fp_acc_l1 | input | 2 | Level 1 FP access field |
| fp_acc_l2 | input | 2 | Level 2 FP access field (host mode) |
| fp_trap_l2 | input | 1 | Level 2 FP trap bit |
| fp_trap_l3 | input | 1 | Level 3 FP trap bit |
| early_undef | input | 1 | Early-undefined option |
| undef_on_trap | input | 1 | Turn level-3 traps into undefined |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| grant | output | 1 | Access allowed |
| undef | output | 1 | Undefined instruction |
| trap | output | 1 | Access traps |
| tgt_lvl | output | 2 | Trap target level |
| exc_class | output | 6 | Trap exception class |

## Verification
The hardest outcome to reach from the ports is a level-3 trap at levels 0 to 2, and its conversion to undefined. It needs every earlier check in the chain to pass first: the enables, the FP access fields and the level-2 trap bit. Random input vectors almost never line all of these up. The stimulus therefore starts each directed case from a fully permissive base vector and clears or sets one or two fields. It then toggles `undef_on_trap` and `acc_write` against that same base. Random vectors are still compared every clock with the behavioural model.

// File: rtl/fpmc_pkg.sv
package fpmc_pkg;

    parameter int LVL_W = 2;
    parameter int CLS_W = 6;

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [CLS_W-1:0] cls_t;

    localparam lvl_t LV_USER   = lvl_t'(0);
    localparam lvl_t LV_KERNEL = lvl_t'(1);
    localparam lvl_t LV_HYP    = lvl_t'(2);
    localparam lvl_t LV_MON    = lvl_t'(3);

    localparam cls_t CLS_NONE    = cls_t'(8'h00);
    localparam cls_t CLS_FP_GEN  = cls_t'(8'h00);
    localparam cls_t CLS_FP_ACC  = cls_t'(8'h07);
    localparam cls_t CLS_MODE_EN = cls_t'(8'h18);

    typedef enum logic [1:0] {
        VD_UNDEF = 2'd0,
        VD_GRANT = 2'd1,
        VD_TRAP  = 2'd2
    } verdict_e;

    typedef struct packed {
        verdict_e vd;
        lvl_t     tgt;
        cls_t     cls;
        logic     l3_fold;
    } result_t;

    typedef struct packed {
        logic       feat;
        logic       l3_present;
        logic       l2_active;
        logic       host_l0;
        logic       host_l2;
        logic       tge;
        logic       ext2_on;
        logic       me_l1;
        logic       me_l2h;
        logic       me_ext2;
        logic       me_l3;
        logic [1:0] fp_l1;
        logic [1:0] fp_l2;
        logic       tp_l2;
        logic       tp_l3;
        logic       early;
    } ctl_t;

    function automatic result_t res_undef();
        return '{vd: VD_UNDEF, tgt: '0, cls: CLS_NONE, l3_fold: 1'b0};
    endfunction

    function automatic result_t res_grant();
        return '{vd: VD_GRANT, tgt: '0, cls: CLS_NONE, l3_fold: 1'b0};
    endfunction

    function automatic result_t res_trap(lvl_t t, cls_t c, logic f);
        return '{vd: VD_TRAP, tgt: t, cls: c, l3_fold: f};
    endfunction

endpackage

// File: rtl/fpmc_lvl_chain.sv
module fpmc_lvl_chain
    import fpmc_pkg::*;
(
    input  ctl_t    c,
    input  lvl_t    cur_lvl,
    output result_t raw
);

    function automatic result_t eval_user(ctl_t k);
        result_t r;
        if (!k.host_l0 && !k.me_l1)
            r = res_trap((k.l2_active && k.tge) ? LV_HYP : LV_KERNEL, CLS_MODE_EN, 1'b0);
        else if (k.host_l0 && !k.me_l2h)
            r = res_trap(LV_HYP, CLS_MODE_EN, 1'b0);
        else if (k.l2_active && !k.host_l0 && (!k.ext2_on || !k.me_ext2))
            r = res_trap(LV_HYP, CLS_MODE_EN, 1'b0);
        else if (k.l3_present && !k.me_l3)
            r = res_trap(LV_MON, CLS_MODE_EN, 1'b1);
        else if (!k.host_l0 && k.fp_l1 != 2'b11)
            r = (k.l2_active && k.tge) ? res_trap(LV_HYP, CLS_FP_GEN, 1'b0)
                                       : res_trap(LV_KERNEL, CLS_FP_ACC, 1'b0);
        else if (k.host_l0 && k.fp_l2 != 2'b11)
            r = res_trap(LV_HYP, CLS_FP_ACC, 1'b0);
        else if (k.host_l2 && !k.fp_l2[0])
            r = res_trap(LV_HYP, CLS_FP_ACC, 1'b0);
        else if (k.l2_active && !k.host_l2 && k.tp_l2)
            r = res_trap(LV_HYP, CLS_FP_ACC, 1'b0);
        else if (k.l3_present && k.tp_l3)
            r = res_trap(LV_MON, CLS_FP_ACC, 1'b1);
        else
            r = res_grant();
        return r;
    endfunction

    function automatic result_t eval_kernel(ctl_t k);
        result_t r;
        if (k.l2_active && !k.host_l0 && (!k.ext2_on || !k.me_ext2))
            r = res_trap(LV_HYP, CLS_MODE_EN, 1'b0);
        else if (k.l3_present && !k.me_l3)
            r = res_trap(LV_MON, CLS_MODE_EN, 1'b1);
        else if (!k.fp_l1[0])
            r = res_trap(LV_KERNEL, CLS_FP_ACC, 1'b0);
        else if (k.l2_active && !k.host_l2 && k.tp_l2)
            r = res_trap(LV_HYP, CLS_FP_ACC, 1'b0);
        else if (k.host_l2 && !k.fp_l2[0])
            r = res_trap(LV_HYP, CLS_FP_ACC, 1'b0);
        else if (k.l3_present && k.tp_l3)
            r = res_trap(LV_MON, CLS_FP_ACC, 1'b1);
        else
            r = res_grant();
        return r;
    endfunction

    function automatic result_t eval_hyp(ctl_t k);
        result_t r;
        if (k.l3_present && !k.me_l3)
            r = res_trap(LV_MON, CLS_MODE_EN, 1'b1);
        else if (!k.host_l2 && k.tp_l2)
            r = res_trap(LV_HYP, CLS_FP_ACC, 1'b0);
        else if (k.host_l2 && !k.fp_l2[0])
            r = res_trap(LV_HYP, CLS_FP_ACC, 1'b0);
        else if (k.l3_present && k.tp_l3)
            r = res_trap(LV_MON, CLS_FP_ACC, 1'b1);
        else
            r = res_grant();
        return r;
    endfunction

    logic early_hit;
    assign early_hit = c.l3_present && c.early && (!c.me_l3 || c.tp_l3);

    always_comb begin
        raw = res_undef();
        if (c.feat) begin
            unique case (cur_lvl)
                LV_USER:   raw = early_hit ? res_undef() : eval_user(c);
                LV_KERNEL: raw = early_hit ? res_undef() : eval_kernel(c);
                LV_HYP:    raw = early_hit ? res_undef() : eval_hyp(c);
                LV_MON:    raw = c.tp_l3 ? res_trap(LV_MON, CLS_FP_ACC, 1'b0) : res_grant();
                default:   raw = res_undef();
            endcase
        end
    end

endmodule

// File: rtl/fpmc_fold.sv
module fpmc_fold
    import fpmc_pkg::*;
(
    input  result_t raw,
    input  logic    fold_en,
    output result_t fin
);

    always_comb begin
        fin = raw;
        if (raw.vd == VD_TRAP && raw.l3_fold && fold_en)
            fin = res_undef();
    end

endmodule

// File: rtl/fpmc_verdict_reg.sv
module fpmc_verdict_reg
    import fpmc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  result_t nxt,
    output logic    grant,
    output logic    undef,
    output logic    trap,
    output lvl_t    tgt_lvl,
    output cls_t    exc_class
);

    verdict_e state_q;
    lvl_t     tgt_q;
    cls_t     cls_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VD_UNDEF;
            tgt_q   <= '0;
            cls_q   <= CLS_NONE;
        end else begin
            state_q <= nxt.vd;
            tgt_q   <= (nxt.vd == VD_TRAP) ? nxt.tgt : '0;
            cls_q   <= (nxt.vd == VD_TRAP) ? nxt.cls : CLS_NONE;
        end
    end

    always_comb begin
        grant     = 1'b0;
        undef     = 1'b0;
        trap      = 1'b0;
        tgt_lvl   = '0;
        exc_class = CLS_NONE;
        unique case (state_q)
            VD_GRANT: grant = 1'b1;
            VD_TRAP: begin
                trap      = 1'b1;
                tgt_lvl   = tgt_q;
                exc_class = cls_q;
            end
            default:  undef = 1'b1;
        endcase
    end

endmodule

// File: rtl/fpmc_access_arbiter.sv
module fpmc_access_arbiter
    import fpmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feat_present,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             l3_present,
    input  logic             l2_active,
    input  logic             host_l0,
    input  logic             host_l2,
    input  logic             trap_general,
    input  logic             ext2_on,
    input  logic             mode_en_l1,
    input  logic             mode_en_l2h,
    input  logic             mode_en_ext2,
    input  logic             mode_en_l3,
    input  logic [1:0]       fp_acc_l1,
    input  logic [1:0]       fp_acc_l2,
    input  logic             fp_trap_l2,
    input  logic             fp_trap_l3,
    input  logic             early_undef,
    input  logic             undef_on_trap,
    input  logic             acc_write,
    output logic             grant,
    output logic             undef,
    output logic             trap,
    output logic [LVL_W-1:0] tgt_lvl,
    output logic [CLS_W-1:0] exc_class
);

    ctl_t    ctl;
    result_t raw_res;
    result_t fin_res;

    assign ctl = '{
        feat:       feat_present,
        l3_present: l3_present,
        l2_active:  l2_active,
        host_l0:    host_l0,
        host_l2:    host_l2,
        tge:        trap_general,
        ext2_on:    ext2_on,
        me_l1:      mode_en_l1,
        me_l2h:     mode_en_l2h,
        me_ext2:    mode_en_ext2,
        me_l3:      mode_en_l3,
        fp_l1:      fp_acc_l1,
        fp_l2:      fp_acc_l2,
        tp_l2:      fp_trap_l2,
        tp_l3:      fp_trap_l3,
        early:      early_undef
    };

    fpmc_lvl_chain u_chain (
        .c       (ctl),
        .cur_lvl (cur_lvl),
        .raw     (raw_res)
    );

    fpmc_fold u_fold (
        .raw     (raw_res),
        .fold_en (undef_on_trap),
        .fin     (fin_res)
    );

    fpmc_verdict_reg u_vreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt       (fin_res),
        .grant     (grant),
        .undef     (undef),
        .trap      (trap),
        .tgt_lvl   (tgt_lvl),
        .exc_class (exc_class)
    );

endmodule

// File: rtl/fpmc_access_chk.sv
module fpmc_access_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       feat_present,
    input logic [1:0] cur_lvl,
    input logic       l3_present,
    input logic       l2_active,
    input logic       host_l0,
    input logic       host_l2,
    input logic       trap_general,
    input logic       ext2_on,
    input logic       mode_en_l1,
    input logic       mode_en_l2h,
    input logic       mode_en_ext2,
    input logic       mode_en_l3,
    input logic [1:0] fp_acc_l1,
    input logic [1:0] fp_acc_l2,
    input logic       fp_trap_l2,
    input logic       fp_trap_l3,
    input logic       early_undef,
    input logic       undef_on_trap,
    input logic       acc_write,
    input logic       grant,
    input logic       undef,
    input logic       trap,
    input logic [1:0] tgt_lvl,
    input logic [5:0] exc_class
);

    logic        armed;
    logic [20:0] ctl_vec;
    logic [10:0] out_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assign ctl_vec = {feat_present, cur_lvl, l3_present, l2_active, host_l0, host_l2,
                      trap_general, ext2_on, mode_en_l1, mode_en_l2h, mode_en_ext2,
                      mode_en_l3, fp_acc_l1, fp_acc_l2, fp_trap_l2, fp_trap_l3,
                      early_undef, undef_on_trap};
    assign out_vec = {grant, undef, trap, tgt_lvl, exc_class};

    assert_one_verdict_R2: assert property (@(posedge clk)
        $countones({grant, undef, trap}) == 1);

    assert_quiet_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |-> (tgt_lvl == 2'd0 && exc_class == 6'h00));

    assert_no_feature_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !feat_present |=> undef);

    assert_early_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_present && cur_lvl != 2'd3 && l3_present && early_undef &&
         (!mode_en_l3 || fp_trap_l3)) |=> undef);

    assert_no_l3_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_present && cur_lvl != 2'd3 && undef_on_trap) |=> !(trap && tgt_lvl == 2'd3));

    assert_top_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (feat_present && cur_lvl == 2'd3) |=>
            (($past(fp_trap_l3) && trap && tgt_lvl == 2'd3 && exc_class == 6'h07) ||
             (!$past(fp_trap_l3) && grant)));

    assert_known_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (exc_class == 6'h00 || exc_class == 6'h07 || exc_class == 6'h18));

    assert_write_blind_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && ctl_vec == $past(ctl_vec) && acc_write != $past(acc_write)) |=>
            out_vec == $past(out_vec));

endmodule

bind fpmc_access_arbiter fpmc_access_chk u_chk (
    .clk(clk), .rst_n(rst_n), .feat_present(feat_present), .cur_lvl(cur_lvl),
    .l3_present(l3_present), .l2_active(l2_active), .host_l0(host_l0),
    .host_l2(host_l2), .trap_general(trap_general), .ext2_on(ext2_on),
    .mode_en_l1(mode_en_l1), .mode_en_l2h(mode_en_l2h), .mode_en_ext2(mode_en_ext2),
    .mode_en_l3(mode_en_l3), .fp_acc_l1(fp_acc_l1), .fp_acc_l2(fp_acc_l2),
    .fp_trap_l2(fp_trap_l2), .fp_trap_l3(fp_trap_l3), .early_undef(early_undef),
    .undef_on_trap(undef_on_trap), .acc_write(acc_write), .grant(grant),
    .undef(undef), .trap(trap), .tgt_lvl(tgt_lvl), .exc_class(exc_class)
);

// File: tb/tb_fpmc_access_arbiter.sv
module tb_fpmc_access_arbiter;

    typedef struct packed {
        logic       wr;
        logic [1:0] lvl;
        logic       feat, l3p, l2a, h0, h2, tge, ext, me1, meh, mex, me3;
        logic [1:0] fp1, fp2;
        logic       tp2, tp3, early, fold;
    } vec_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    vec_t v = '0;
    logic grant, undef, trap;
    logic [1:0] tgt_lvl;
    logic [5:0] exc_class;
    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    always #2 clk = ~clk;

    fpmc_access_arbiter dut (
        .clk(clk), .rst_n(rst_n), .feat_present(v.feat), .cur_lvl(v.lvl),
        .l3_present(v.l3p), .l2_active(v.l2a), .host_l0(v.h0), .host_l2(v.h2),
        .trap_general(v.tge), .ext2_on(v.ext), .mode_en_l1(v.me1),
        .mode_en_l2h(v.meh), .mode_en_ext2(v.mex), .mode_en_l3(v.me3),
        .fp_acc_l1(v.fp1), .fp_acc_l2(v.fp2), .fp_trap_l2(v.tp2),
        .fp_trap_l3(v.tp3), .early_undef(v.early), .undef_on_trap(v.fold),
        .acc_write(v.wr), .grant(grant), .undef(undef), .trap(trap),
        .tgt_lvl(tgt_lvl), .exc_class(exc_class)
    );

    localparam logic [10:0] EXP_UND = {3'b010, 8'h00};
    localparam logic [10:0] EXP_GR  = {3'b100, 8'h00};

    function automatic logic [10:0] tr(int l, int c);
        return {3'b001, 2'(l), 6'(c)};
    endfunction

    // behavioural model: first matching cause in priority order wins
    function automatic logic [10:0] model(vec_t s);
        int l = int'(s.lvl);
        if (!s.feat) return EXP_UND;
        if (l == 3) return s.tp3 ? tr(3, 7) : EXP_GR;
        if (s.l3p && s.early && (!s.me3 || s.tp3)) return EXP_UND;
        if (l == 0 && !s.h0 && !s.me1) return tr((s.l2a && s.tge) ? 2 : 1, 'h18);
        if (l == 0 && s.h0 && !s.meh) return tr(2, 'h18);
        if (l < 2 && s.l2a && !s.h0 && (!s.ext || !s.mex)) return tr(2, 'h18);
        if (s.l3p && !s.me3) return s.fold ? EXP_UND : tr(3, 'h18);
        if (l == 0 && !s.h0 && s.fp1 != 2'b11) return (s.l2a && s.tge) ? tr(2, 0) : tr(1, 7);
        if (l == 0 && s.h0 && s.fp2 != 2'b11) return tr(2, 7);
        if (l == 1 && !s.fp1[0]) return tr(1, 7);
        if (s.h2 && !s.fp2[0]) return tr(2, 7);
        if (!s.h2 && s.tp2 && (l == 2 || s.l2a)) return tr(2, 7);
        if (s.l3p && s.tp3) return s.fold ? EXP_UND : tr(3, 7);
        return EXP_GR;
    endfunction

    task automatic compare(logic [10:0] exp, string tag);
        logic [10:0] act = {grant, undef, trap, tgt_lvl, exc_class};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual g/u/t=%b tgt=%0d cls=%h expected g/u/t=%b tgt=%0d cls=%h",
                     tag, act[10:8], act[7:6], act[5:0], exp[10:8], exp[7:6], exp[5:0]);
        end
    endtask

    // drive at a falling edge; result registered at the next rising edge
    task automatic apply(vec_t s, string tag);
        v = s;
        @(negedge clk);
        compare(model(s), tag);
    endtask

    task automatic apply_exp(vec_t s, logic [10:0] exp, string tag);
        v = s;
        @(negedge clk);
        compare(exp, tag);
    endtask

    function automatic vec_t base(int l);
        vec_t s = '0;
        s.lvl = 2'(l); s.feat = 1; s.l3p = 1; s.l2a = 1; s.ext = 1;
        s.me1 = 1; s.meh = 1; s.mex = 1; s.me3 = 1; s.fp1 = 2'b11; s.fp2 = 2'b11;
        return s;
    endfunction

    initial begin
        vec_t s;
        repeat (3) @(negedge clk);
        compare(EXP_UND, "R11 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        compare(EXP_UND, "R11 idle after reset");

        for (int l = 0; l < 4; l++) apply_exp(base(l), EXP_GR, "R2 permissive grant");

        for (int l = 0; l < 4; l++) begin
            s = base(l); s.feat = 0; s.tp3 = 1; s.me1 = 0;
            apply_exp(s, EXP_UND, "R1 feature absent");
        end

        s = base(1); s.early = 1; s.me3 = 0; s.fp1 = 2'b00;
        apply_exp(s, EXP_UND, "R3 early undef on enable");
        s = base(0); s.early = 1; s.tp3 = 1; s.me1 = 0;
        apply_exp(s, EXP_UND, "R3 early undef on trap bit");
        s = base(0); s.early = 1; s.l3p = 0; s.me3 = 0;
        apply_exp(s, EXP_GR, "R3 early option without level 3");

        s = base(0); s.me1 = 0;
        apply_exp(s, tr(1, 'h18), "R4 level1 enable");
        s.tge = 1;
        apply_exp(s, tr(2, 'h18), "R4 level1 enable rerouted");
        s = base(0); s.h0 = 1; s.h2 = 1; s.meh = 0;
        apply_exp(s, tr(2, 'h18), "R4 host enable");
        s = base(1); s.ext = 0;
        apply_exp(s, tr(2, 'h18), "R4 extension off");
        s = base(2); s.me3 = 0;
        apply_exp(s, tr(3, 'h18), "R4 level3 enable");

        s = base(0); s.fp1 = 2'b01;
        apply_exp(s, tr(1, 7), "R5 level0 field 01");
        s.fp1 = 2'b10;
        apply_exp(s, tr(1, 7), "R5 level0 field 10");
        s.tge = 1;
        apply_exp(s, tr(2, 0), "R5 rerouted class 0");

        s = base(1); s.fp1 = 2'b01;
        apply_exp(s, EXP_GR, "R6 level1 field 01");
        s.fp1 = 2'b10;
        apply_exp(s, tr(1, 7), "R6 level1 field 10");
        s = base(2); s.h2 = 1; s.fp2 = 2'b10;
        apply_exp(s, tr(2, 7), "R6 level2 host field 10");
        s.fp2 = 2'b01;
        apply_exp(s, EXP_GR, "R6 level2 host field 01");

        s = base(0); s.me1 = 0; s.fp1 = 2'b00;
        apply_exp(s, tr(1, 'h18), "R7 enable beats access field");
        s = base(1); s.me3 = 0; s.fp1 = 2'b00;
        apply_exp(s, tr(3, 'h18), "R7 level3 enable beats field");
        s = base(2); s.tp2 = 1; s.tp3 = 1;
        apply_exp(s, tr(2, 7), "R7 level2 trap before level3");

        s = base(2); s.tp3 = 1;
        apply_exp(s, tr(3, 7), "R8 level3 trap kept");
        s.fold = 1;
        apply_exp(s, EXP_UND, "R8 level3 trap folded");
        s = base(0); s.me3 = 0; s.fold = 1;
        apply_exp(s, EXP_UND, "R8 level3 enable folded");
        s = base(1); s.fp1 = 2'b00; s.fold = 1;
        apply_exp(s, tr(1, 7), "R8 lower trap not folded");

        s = base(3); s.tp3 = 1; s.fold = 1; s.early = 1;
        apply_exp(s, tr(3, 7), "R9 top level trap");
        s = base(3); s.me3 = 0; s.me1 = 0; s.fp1 = 2'b00; s.tp2 = 1;
        apply_exp(s, EXP_GR, "R9 top level ignores others");

        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom();
            s = r[21:0]; s.feat = 1;
            s.wr = 0; apply(s, "R10 read");
            s.wr = 1; apply(s, "R10 write");
        end

        for (int i = 0; i < 6000; i++) begin
            logic [31:0] r = $urandom();
            s = r[21:0];
            if (i % 3 != 0) begin
                s.feat = 1; s.me1 = 1; s.meh = 1; s.mex = 1; s.ext = 1;
                s.fp1 = 2'b11;
            end
            apply(s, "R2 random vector");
        end

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual running expected finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule